// File: doc/BRIEF.md
# Clear-On-Read ADC Peak Level Detector

This block watches two streams of two's-complement audio samples, one per ADC channel. For each channel it keeps the largest absolute sample value seen since that channel was last read. Each sample arrives with its own valid strobe.

A read port picks a channel. One cycle later it returns that channel's held peak as a 6-bit attenuation code below full scale, in 1 dB steps. Code 0 means full scale and code 63 means the floor. The read also empties the channel's hold register, so a fresh measurement begins.

The dB conversion compares the held magnitude against a table of constant thresholds. The table is computed when the design elaborates. A sample that arrives in the same cycle as a read of its channel is not lost: it becomes the first value of the new measurement, and the read reports the old peak.

Top module: `peak_level_mon`

## Requirements
- R1: After reset, rd_valid is 0 and both held peaks are zero, so a read of either channel returns code 63.
- R2: The magnitude of a sample is its absolute value. The most negative value (-2^(W-1)) saturates to 2^(W-1)-1.
- R3: Each channel holds the largest sample magnitude received since its last clear. Lower later samples leave the held value unchanged. The channels are independent.
- R4: With T(k) = floor((2^(W-1)-1) * 10^(-k/20)), the reported code is the number of k in 0..62 for which the held magnitude is below T(k). Full scale therefore gives 0, and anything below T(62) gives 63.
- R5: A read is issued by holding rd_en high for one cycle, with rd_ch = 0 for channel 0 or 1 for channel 1. At the next clock rd_valid is 1 and rd_code is the code of the peak that was held before that edge. In every cycle without a read, rd_valid is 0.
- R6: A read clears the held peak of the channel it selects. A second read with no samples in between returns 63. The other channel keeps its peak.
- R7: If a valid sample for a channel arrives in the same cycle as a read of that channel, the read reports the old peak. The held value then becomes that sample's magnitude.
- R8: Sample data with its valid bit low has no effect on the held peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | NUM_CH*W | Sample lanes; channel c occupies bits [c*W +: W] |
| smp_valid | input | NUM_CH | Per-channel sample strobe |
| rd_en | input | 1 | Read request, one cycle |
| rd_ch | input | SEL_W | Channel selected by the read |
| rd_valid | output | 1 | High the cycle after a read |
| rd_code | output | CODE_W | Attenuation code, 0 = full scale, 63 = floor |

## Verification
A wrong hold register, whether stale, uncleared or holding a lower value, shows up only through the code returned one cycle after the next read of that channel. The bench therefore pairs every stimulus with a read and checks the code right away. A misplaced threshold or a bad saturation shows as a code that is off by one. The bench sweeps every threshold and the value just below it, with both signs. A clear-ordering error shows on the read that follows a sample landing in the same cycle as a read.

// File: rtl/peak_level_pkg.sv
package peak_level_pkg;

    // Magnitude threshold for attenuation step 'step' below full scale.
    function automatic longint db_threshold(input int width, input int step);
        real full;
        full = real'((longint'(1) << (width - 1)) - 1);
        return longint'($floor(full * (10.0 ** (-real'(step) / 20.0))));
    endfunction

endpackage

// File: rtl/peak_mag.sv
module peak_mag #(
    parameter int W = 24
) (
    input  logic [W-1:0] smp,
    output logic [W-2:0] mag
);
    always_comb begin
        if (!smp[W-1]) begin
            mag = smp[W-2:0];
        end else if (smp[W-2:0] == '0) begin
            mag = '1;                     // most negative value saturates
        end else begin
            mag = (~smp[W-2:0]) + 1'b1;
        end
    end
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
    parameter int MW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [MW-1:0] mag,
    input  logic          clr,
    output logic [MW-1:0] peak
);
    typedef struct packed {
        logic [MW-1:0] peak;
    } hold_t;

    hold_t st_d, st_q;
    logic [MW-1:0] base;

    always_comb begin
        st_d = st_q;
        base = clr ? '0 : st_q.peak;
        if (vld && (mag > base)) st_d.peak = mag;
        else                     st_d.peak = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign peak = st_q.peak;

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (st_q.peak >= $past(mag)));
    assert_no_decay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.peak >= $past(st_q.peak)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !vld) |=> (st_q.peak == '0));
    assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && vld) |=> (st_q.peak == $past(mag)));
    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !vld) |=> $stable(st_q.peak));
endmodule

// File: rtl/peak_db_encode.sv
module peak_db_encode #(
    parameter int MW     = 23,
    parameter int CODE_W = 6
) (
    input  logic [MW-1:0]     mag,
    output logic [CODE_W-1:0] code
);
    localparam int STEPS = (1 << CODE_W) - 1;

    logic [STEPS-1:0] below;

    for (genvar k = 0; k < STEPS; k++) begin : g_thr
        localparam longint THR = peak_level_pkg::db_threshold(MW + 1, k);
        assign below[k] = (64'(mag) < 64'(THR));
    end

    always_comb begin
        code = CODE_W'($countones(below));
    end
endmodule

// File: rtl/peak_level_mon.sv
module peak_level_mon #(
    parameter int W      = 24,
    parameter int NUM_CH = 2,
    parameter int CODE_W = 6,
    parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH*W-1:0] smp_data,
    input  logic [NUM_CH-1:0]   smp_valid,
    input  logic                rd_en,
    input  logic [SEL_W-1:0]    rd_ch,
    output logic                rd_valid,
    output logic [CODE_W-1:0]   rd_code
);
    localparam int MW = W - 1;

    typedef struct packed {
        logic              rd_valid;
        logic [CODE_W-1:0] rd_code;
    } out_t;

    out_t              out_d, out_q;
    logic [NUM_CH-1:0] clr;
    logic [MW-1:0]     mag  [NUM_CH];
    logic [MW-1:0]     peak [NUM_CH];
    logic [MW-1:0]     sel_peak;
    logic [CODE_W-1:0] sel_code;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign clr[c] = rd_en && (rd_ch == SEL_W'(c));

        peak_mag #(.W(W)) u_mag (
            .smp (smp_data[c*W +: W]),
            .mag (mag[c])
        );

        peak_hold #(.MW(MW)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (smp_valid[c]),
            .mag   (mag[c]),
            .clr   (clr[c]),
            .peak  (peak[c])
        );
    end

    always_comb begin
        sel_peak = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == SEL_W'(c)) sel_peak = peak[c];
        end
    end

    peak_db_encode #(.MW(MW), .CODE_W(CODE_W)) u_enc (
        .mag  (sel_peak),
        .code (sel_code)
    );

    always_comb begin
        out_d          = out_q;
        out_d.rd_valid = rd_en;
        if (rd_en) out_d.rd_code = sel_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_valid = out_q.rd_valid;
    assign rd_code  = out_q.rd_code;

    assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_idle_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    assert_one_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
endmodule

// File: tb/peak_level_mon_tb.sv
`timescale 1ns/1ps
module peak_level_mon_tb_top;
    localparam int W      = 24;
    localparam int NUM_CH = 2;
    localparam int CODE_W = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_CH*W-1:0] smp_data = '0;
    logic [NUM_CH-1:0]   smp_valid = '0;
    logic                rd_en = 1'b0;
    logic                rd_ch = 1'b0;
    logic                rd_valid;
    logic [CODE_W-1:0]   rd_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    peak_level_mon #(.W(W), .NUM_CH(NUM_CH), .CODE_W(CODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .rd_en(rd_en), .rd_ch(rd_ch), .rd_valid(rd_valid), .rd_code(rd_code)
    );

    function automatic longint thr(int k);
        real fs;
        fs = real'((longint'(1) << (W - 1)) - 1);
        return longint'($floor(fs * (10.0 ** (-real'(k) / 20.0))));
    endfunction

    function automatic longint magn(longint v);
        if (v == -(longint'(1) << (W - 1))) return (longint'(1) << (W - 1)) - 1;
        return (v < 0) ? -v : v;
    endfunction

    function automatic int exp_code(longint m);
        int n = 0;
        for (int k = 0; k < 63; k++) if (m < thr(k)) n++;
        return n;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic put(int ch, longint v);
        smp_data[ch*W +: W] = W'(v);
        smp_valid[ch] = 1'b1;
        @(negedge clk);
        smp_valid = '0;
    endtask

    task automatic read_chk(int ch, int exp, string req);
        rd_en = 1'b1;
        rd_ch = ch[0];
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " rd_valid"}, rd_valid, 1);
        chk({req, " code"}, rd_code, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_valid after reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 idle rd_valid", rd_valid, 0);
        read_chk(0, 63, "R1 ch0 empty");
        read_chk(1, 63, "R1 ch1 empty");

        // R4 / R2: sweep every threshold and one below it, both signs, both channels
        for (int k = 0; k < 63; k++) begin
            for (int off = 0; off < 2; off++) begin
                longint v = thr(k) - off;
                int ch = (k + off) % 2;
                if (k % 2 == 1) v = -v;
                put(ch, v);
                read_chk(ch, exp_code(magn(v)), "R4 sweep");
            end
        end

        // R2: saturation of most negative, plus max positive
        put(0, -(longint'(1) << (W - 1)));
        read_chk(0, 0, "R2 most negative");
        put(1, (longint'(1) << (W - 1)) - 1);
        read_chk(1, 0, "R2 max positive");
        put(1, -1);
        read_chk(1, exp_code(1), "R2 minus one");

        // R3: peak held across lower samples; channels independent
        put(0, 100);
        put(0, -5000000);
        put(0, 200);
        put(1, 30000);
        read_chk(0, exp_code(5000000), "R3 hold max ch0");
        read_chk(1, exp_code(30000), "R3 ch1 independent");

        // R6: clear on read; other channel untouched
        put(0, 700000);
        put(1, 9000);
        read_chk(0, exp_code(700000), "R6 first read");
        read_chk(0, 63, "R6 second read empty");
        read_chk(1, exp_code(9000), "R6 other channel kept");

        // R7: sample in the same cycle as a read
        put(0, 4000000);
        smp_data[0 +: W] = W'(longint'(1234));
        smp_valid[0] = 1'b1;
        rd_en = 1'b1;
        rd_ch = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        smp_valid = '0;
        chk("R7 read returns old peak", rd_code, exp_code(4000000));
        read_chk(0, exp_code(1234), "R7 sample starts new window");

        // R8: data without valid ignored
        smp_data = {W'(longint'(8000000)), W'(longint'(8000000))};
        smp_valid = '0;
        repeat (3) @(negedge clk);
        chk("R5 no read no valid", rd_valid, 0);
        read_chk(0, 63, "R8 ch0 ignored");
        read_chk(1, 63, "R8 ch1 ignored");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule